// File: doc/BRIEF.md
# MIL-STD-1553 Manchester Word Encoder with Fault Injection

This block turns one 16-bit word into a serial Manchester II bi-phase frame for a MIL-STD-1553 bus: a sync field three bit-times long, sixteen data bits sent most significant first, and one odd-parity bit. The sync polarity marks the frame as a command/status word or as a data word. The output is a pair of complementary drive levels plus a transmit-enable, which feed an external transceiver. A one-cycle start strobe launches a word. While the frame is on the line, busy stays high. A one-cycle done pulse marks the end of the frame.

For terminal protocol testing, every transmission carries a fault descriptor, and the same word can go out clean or deliberately broken. The descriptor is a kind field and an argument. It can invert the parity bit, swap the sync polarity, suppress the mid-bit transition of one chosen bit, append up to three extra bits, or cut up to three bits off the end of the frame. The parameter HALF_CYCLES sets the length of one half-bit in clock cycles. It is 50 for a 100 MHz clock at 1 Mbit/s.

Top module: `m1553_tx_encoder`

## Requirements
- R1: After reset, and whenever no frame is being sent, tx_p, tx_n, tx_en, busy and done are all 0.
- R2: A start pulse seen with busy low loads the frame. busy and tx_en are high from the next cycle for exactly len*HALF_CYCLES cycles, where len is the number of half-bits in the frame (40 for a normal word). In the cycle busy falls, done is high for one cycle only.
- R3: While tx_en is high, tx_n is the complement of tx_p. Each half-bit level lasts HALF_CYCLES clocks. A data bit of value 1 is sent high then low, and a 0 is sent low then high. Data bits go out from word[15] down to word[0].
- R4: With sync_cmd=1 the sync field is high for three half-bits and then low for three half-bits. With sync_cmd=0 it is low for three and then high for three.
- R5: After the 16 data bits comes one parity bit, chosen so that the 17 bits hold an odd number of ones.
- R6: err_kind encodings: 0 means no fault, and the values 6 and 7 also mean no fault. With err_kind=1 the parity bit is inverted.
- R7: With err_kind=2 the sync field of the opposite type is sent. Data and parity are unchanged.
- R8: With err_kind=3 the bit at index err_arg keeps its first-half level through its second half, so it has no mid-bit transition. Index 0 is word[15], 15 is word[0], and 16 is the parity bit. An index above 16 sends the word unchanged.
- R9: With err_kind=4 and err_arg in 1..3, that many extra logic-1 bits follow the parity bit. With err_kind=5 and err_arg in 1..3, that many bits are dropped from the end: the parity bit first, then word[0], then word[1]. An err_arg of 0 or above 3 leaves the length at 40 half-bits.
- R10: A start pulse while busy is high is ignored. The frame in progress continues unchanged, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to send a word |
| word | input | DATA_W | Data bits of the word, sampled with start |
| sync_cmd | input | 1 | 1 = command/status sync, 0 = data sync |
| err_kind | input | 3 | Fault kind, sampled with start |
| err_arg | input | ARG_W | Bit index or bit count for the fault |
| tx_p | output | 1 | True drive level, 0 when idle |
| tx_n | output | 1 | Complement drive level, 0 when idle |
| tx_en | output | 1 | Transmitter enable |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The bench builds the block with HALF_CYCLES=2 and keeps the defaults DATA_W=16 and MAX_EXTRA=3. A full frame then takes only 80 cycles, so a single run can cover every fault kind at its edges: the Manchester fault at index 0, at index 16 and out of range, and the added and dropped counts of 1 and 3 along with the invalid count 0. It also covers the unused kind codes, both sync types, all-zero and all-one words, and a start pulse arriving in the middle of a frame. With two clocks per half-bit, the bench also checks that each level holds for exactly its two cycles and that the frame ends on the right cycle.

// File: rtl/m1553_pkg.sv
// Shared encodings for the 1553 word encoder.
// Assumes: err_kind values outside the enum behave as "no fault".
package m1553_pkg;
    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_PARITY = 3'd1,
        ERR_SYNC   = 3'd2,
        ERR_MANCH  = 3'd3,
        ERR_LONG   = 3'd4,
        ERR_SHORT  = 3'd5
    } err_kind_e;

    localparam int SYNC_HALVES = 6;
endpackage

// File: rtl/m1553_half_timer.sv
// Half-bit timer: counts HALF_CYCLES clocks while run is high and flags
// the last cycle of each half-bit. Assumes: HALF_CYCLES >= 1.
module m1553_half_timer #(
    parameter int HALF_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Count within a half-bit, hold at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < HALF_CYCLES); // R3
endmodule

// File: rtl/m1553_frame_build.sv
// Frame builder: turns word, sync type and fault descriptor into the list of
// half-bit levels (index 0 goes out first) and the frame length in half-bits.
// Purely combinational. Assumes: MAX_EXTRA >= 1.
module m1553_frame_build
    import m1553_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int MAX_EXTRA  = 3,
    parameter int ARG_W      = 5,
    parameter int MAX_HALVES = 46,
    parameter int LEN_W      = 6
) (
    input  logic [DATA_W-1:0]     data,
    input  logic                  sync_cmd,
    input  logic [2:0]            err_kind,
    input  logic [ARG_W-1:0]      err_arg,
    output logic [MAX_HALVES-1:0] levels,
    output logic [LEN_W-1:0]      len
);
    localparam int WORD_BITS   = DATA_W + 1;
    localparam int SEQ_BITS    = WORD_BITS + MAX_EXTRA;
    localparam int BASE_HALVES = SYNC_HALVES + 2 * WORD_BITS;

    logic [SEQ_BITS-1:0] seq;
    logic                par;
    logic                sync_hi;
    logic                cnt_ok;
    int                  len_i;

    // Bit sequence in send order: data MSB first, parity, then extra ones.
    always_comb begin
        par = ~(^data) ^ (err_kind == ERR_PARITY);
        for (int k = 0; k < SEQ_BITS; k++) begin
            if (k < DATA_W)
                seq[k] = data[DATA_W-1-k];
            else if (k == DATA_W)
                seq[k] = par;
            else
                seq[k] = 1'b1;
        end
    end

    // Half-bit levels: sync field followed by Manchester pairs.
    always_comb begin
        sync_hi = sync_cmd ^ (err_kind == ERR_SYNC);
        levels  = '0;
        for (int h = 0; h < SYNC_HALVES / 2; h++) begin
            levels[h]                   = sync_hi;
            levels[h + SYNC_HALVES / 2] = ~sync_hi;
        end
        for (int k = 0; k < SEQ_BITS; k++) begin
            levels[SYNC_HALVES + 2*k]     = seq[k];
            levels[SYNC_HALVES + 2*k + 1] =
                ((err_kind == ERR_MANCH) && (int'(err_arg) == k)) ? seq[k] : ~seq[k];
        end
    end

    // Frame length, stretched or cut by a valid bit-count fault.
    always_comb begin
        cnt_ok = (err_arg != '0) && (int'(err_arg) <= MAX_EXTRA);
        len_i  = BASE_HALVES;
        if (cnt_ok && err_kind == ERR_LONG)
            len_i = BASE_HALVES + 2 * int'(err_arg);
        else if (cnt_ok && err_kind == ERR_SHORT)
            len_i = BASE_HALVES - 2 * int'(err_arg);
        len = LEN_W'(len_i);
    end
endmodule

// File: rtl/m1553_serializer.sv
// Serializer: captures a built frame on an accepted start and steps through
// its half-bit levels on each timer tick. Starts arriving while busy are
// dropped. Assumes: len_in >= 1.
module m1553_serializer #(
    parameter int MAX_HALVES = 46,
    parameter int LEN_W      = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  tick,
    input  logic [MAX_HALVES-1:0] levels_in,
    input  logic [LEN_W-1:0]      len_in,
    output logic                  busy,
    output logic                  done,
    output logic                  line
);
    logic [MAX_HALVES-1:0] lv_q;
    logic [LEN_W-1:0]      len_q;
    logic [LEN_W-1:0]      pos;
    logic                  last;

    assign last = (pos == len_q - 1'b1);

    // Frame capture, half-bit stepping and end-of-frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lv_q  <= '0;
            len_q <= '0;
            pos   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    lv_q  <= levels_in;
                    len_q <= len_in;
                    pos   <= '0;
                    busy  <= 1'b1;
                end
            end else if (tick) begin
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end

    assign line = lv_q[pos];

    AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pos < len_q)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !tick) |=> (busy && $stable(len_q) && $stable(lv_q))); // R10
endmodule

// File: rtl/m1553_tx_encoder.sv
// MIL-STD-1553 word encoder with fault injection (top). Builds the frame
// from the inputs sampled with start, then drives complementary Manchester
// levels with tx_en. Assumes: inputs are held only in the start cycle.
module m1553_tx_encoder
    import m1553_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int HALF_CYCLES = 50,
    parameter int MAX_EXTRA   = 3,
    parameter int ARG_W       = $clog2(DATA_W + 1 + MAX_EXTRA)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] word,
    input  logic              sync_cmd,
    input  logic [2:0]        err_kind,
    input  logic [ARG_W-1:0]  err_arg,
    output logic              tx_p,
    output logic              tx_n,
    output logic              tx_en,
    output logic              busy,
    output logic              done
);
    localparam int WORD_BITS   = DATA_W + 1;
    localparam int BASE_HALVES = SYNC_HALVES + 2 * WORD_BITS;
    localparam int MAX_HALVES  = BASE_HALVES + 2 * MAX_EXTRA;
    localparam int MIN_HALVES  = BASE_HALVES - 2 * MAX_EXTRA;
    localparam int LEN_W       = $clog2(MAX_HALVES + 1);

    logic [MAX_HALVES-1:0] frame_lv;
    logic [LEN_W-1:0]      frame_len;
    logic                  tick;
    logic                  line;

    m1553_frame_build #(
        .DATA_W(DATA_W), .MAX_EXTRA(MAX_EXTRA), .ARG_W(ARG_W),
        .MAX_HALVES(MAX_HALVES), .LEN_W(LEN_W)
    ) u_build (
        .data(word), .sync_cmd(sync_cmd), .err_kind(err_kind),
        .err_arg(err_arg), .levels(frame_lv), .len(frame_len)
    );

    m1553_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
    );

    m1553_serializer #(.MAX_HALVES(MAX_HALVES), .LEN_W(LEN_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
        .levels_in(frame_lv), .len_in(frame_len),
        .busy(busy), .done(done), .line(line)
    );

    assign tx_en = busy;
    assign tx_p  = busy & line;
    assign tx_n  = busy & ~line;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (!tx_p && !tx_n)); // R1
    AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !tick) |=> $stable(tx_p)); // R3
    AST_LEN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(frame_len) >= MIN_HALVES) && (int'(frame_len) <= MAX_HALVES)); // R9
endmodule

// File: tb/m1553_tx_encoder_tb.sv
// Scoreboard bench: the driver pushes expected per-cycle line levels, the
// monitor pops and compares them on every falling edge while tx_en is high.
module m1553_tx_encoder_tb;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] word = '0;
    logic        sync_cmd = 1'b0;
    logic [2:0]  err_kind = '0;
    logic [4:0]  err_arg = '0;
    logic        tx_p, tx_n, tx_en, busy, done;

    int    vectors = 0;
    int    fails = 0;
    string cur_req = "R3";
    bit    exp_q[$];
    bit    finished = 1'b0;

    always #5 clk = ~clk;

    m1553_tx_encoder #(.HALF_CYCLES(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .word(word),
        .sync_cmd(sync_cmd), .err_kind(err_kind), .err_arg(err_arg),
        .tx_p(tx_p), .tx_n(tx_n), .tx_en(tx_en), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Independent model of the expected half-bit stream.
    task automatic expect_word(input logic [15:0] w, input bit cmd,
                               input int kind, input int arg);
        bit hs[$];
        bit seq[$];
        bit p = 1'b1;
        bit s;
        for (int i = 0; i < 16; i++) p ^= w[i];
        if (kind == 1) p = ~p;
        s = (kind == 2) ? ~cmd : cmd;
        for (int i = 0; i < 3; i++) hs.push_back(s);
        for (int i = 0; i < 3; i++) hs.push_back(~s);
        for (int i = 15; i >= 0; i--) seq.push_back(w[i]);
        seq.push_back(p);
        if (kind == 5 && arg >= 1 && arg <= 3)
            for (int i = 0; i < arg; i++) void'(seq.pop_back());
        if (kind == 4 && arg >= 1 && arg <= 3)
            for (int i = 0; i < arg; i++) seq.push_back(1'b1);
        for (int j = 0; j < seq.size(); j++) begin
            hs.push_back(seq[j]);
            hs.push_back((kind == 3 && arg == j) ? seq[j] : ~seq[j]);
        end
        for (int j = 0; j < hs.size(); j++)
            for (int r = 0; r < HALF; r++) exp_q.push_back(hs[j]);
    endtask

    // Drive one word and wait for done. Optional start pulse mid-frame.
    task automatic send(input logic [15:0] w, input bit cmd, input int kind,
                        input int arg, input string req, input bit intrude);
        cur_req = req;
        expect_word(w, cmd, kind, arg);
        @(negedge clk);
        word = w; sync_cmd = cmd; err_kind = 3'(kind); err_arg = 5'(arg);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (intrude) begin
            repeat (9) @(negedge clk);
            word = ~w; sync_cmd = ~cmd; err_kind = 3'd4; err_arg = 5'd3;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        check(!busy && !tx_en && !tx_p && !tx_n, "R1", "idle after frame",
              int'({busy, tx_en, tx_p, tx_n}), 0);
        if (intrude) begin
            repeat (3) @(negedge clk);
            check(!tx_en && !busy, "R10", "no frame after ignored start",
                  int'({tx_en, busy}), 0);
        end
    endtask

    // Monitor: compare each transmitting cycle against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && tx_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "frame longer than expected", 1, 0);
            end else begin
                bit e;
                e = exp_q.pop_front();
                check(tx_p == e, cur_req, "tx_p level", int'(tx_p), int'(e));
                check(tx_n == ~tx_p, "R3", "tx_n complement", int'(tx_n), int'(~tx_p));
                check(busy, "R2", "busy while tx_en", int'(busy), 1);
            end
        end
        if (rst_n && done) begin
            check(exp_q.size() == 0, "R2", "halves left at done", exp_q.size(), 0);
            exp_q.delete();
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!tx_p && !tx_n && !tx_en && !busy && !done, "R1", "reset state",
              int'({tx_p, tx_n, tx_en, busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!tx_p && !tx_n && !tx_en, "R1", "idle after reset",
              int'({tx_p, tx_n, tx_en}), 0);

        send(16'hA5C3, 1'b1, 0, 0, "R4", 1'b0);   // command sync, normal
        send(16'hA5C3, 1'b0, 0, 0, "R4", 1'b0);   // data sync, normal
        send(16'h0000, 1'b0, 0, 0, "R5", 1'b0);   // parity 1
        send(16'hFFFF, 1'b1, 0, 0, "R5", 1'b0);   // parity 1
        send(16'h0001, 1'b1, 0, 0, "R5", 1'b0);   // parity 0, R3 MSB order
        send(16'h1234, 1'b1, 1, 0, "R6", 1'b0);   // parity inverted
        send(16'h1234, 1'b1, 7, 0, "R6", 1'b0);   // unused kind = none
        send(16'h1234, 1'b0, 6, 2, "R6", 1'b0);   // unused kind = none
        send(16'h5A5A, 1'b1, 2, 0, "R7", 1'b0);   // swapped sync
        send(16'h5A5A, 1'b0, 2, 0, "R7", 1'b0);
        send(16'hC001, 1'b1, 3, 0, "R8", 1'b0);   // no transition, index 0
        send(16'hC001, 1'b1, 3, 16, "R8", 1'b0);  // no transition, parity
        send(16'hC001, 1'b0, 3, 7, "R8", 1'b0);
        send(16'hC001, 1'b0, 3, 20, "R8", 1'b0);  // out of range
        send(16'h8421, 1'b1, 4, 1, "R9", 1'b0);   // one extra bit
        send(16'h8421, 1'b0, 4, 3, "R9", 1'b0);   // three extra bits
        send(16'h8421, 1'b1, 5, 1, "R9", 1'b0);   // drop parity
        send(16'h8421, 1'b0, 5, 3, "R9", 1'b0);   // drop three
        send(16'h8421, 1'b1, 4, 0, "R9", 1'b0);   // invalid count
        send(16'h8421, 1'b1, 5, 5, "R9", 1'b0);   // invalid count
        send(16'h3C3C, 1'b1, 0, 0, "R10", 1'b1);  // start while busy

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule